// File: doc/BRIEF.md
# Next-PC Unit with Delay Slot

This block holds the program counter of a five-stage pipeline whose branches and jumps are settled in the decode stage and whose architecture has a single delay slot. While a control-transfer instruction sits in decode, the instruction right behind it, the delay slot, is already in fetch. It is therefore always executed. The redirect target is formed by adding the shifted offset field of the decoded instruction to the address of that delay-slot instruction, which is the current PC.

The unit evaluates the branch condition from three comparison results produced in decode: the two operand registers are equal, the first operand is zero, and the first operand is negative. It picks the sequential address, the branch target or the jump target, and writes the chosen value into the PC register.

Two stall sources freeze the PC: the hazard unit and an instruction-cache miss. A stall overrides any redirect. A redirect seen during a stall is remembered and is applied on the first cycle without a stall. The fetch address sent to instruction memory is the registered PC.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC is loaded with 0 (parameter `RESET_PC`).
- R2: With no stall, no jump, no taken branch and no remembered redirect, the PC advances by 4 at each rising edge.
- R3: A branch is taken according to `br_kind`: 0 when `cmp_eq` is 1, 1 when `cmp_eq` is 0, 2 when `cmp_zero` is 1, 3 when `cmp_neg` is 1. A taken branch with no stall loads the PC with the current PC plus the sign-extended 16-bit `dec_imm16` shifted left by two.
- R4: A branch whose condition is false leaves the PC advancing by 4, so the delay slot and the following instructions are fetched in order.
- R5: A jump with no stall loads the PC with the current PC plus the sign-extended 26-bit `dec_imm26` shifted left by two, whatever the branch inputs are.
- R6: While `hz_stall` or `ic_miss` is high, the PC does not change.
- R7: A redirect present during a stall is not applied while the stall lasts. On the first unstalled edge, the PC is loaded with the target computed during the stall, even if the decode inputs have dropped by then.
- R8: `fetch_addr` always equals `pc_q`.
- R9: Target sums wrap modulo 2^ADDR_W, so a negative offset from a low PC yields a high address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_branch | input | 1 | Decode stage holds a conditional branch |
| dec_jump | input | 1 | Decode stage holds a jump |
| br_kind | input | 2 | Branch condition selector (see R3) |
| cmp_eq | input | 1 | The two source registers are equal |
| cmp_zero | input | 1 | The first source register is zero |
| cmp_neg | input | 1 | The first source register is negative |
| dec_imm16 | input | 16 | Branch offset field, in words |
| dec_imm26 | input | 26 | Jump offset field, in words |
| hz_stall | input | 1 | Stall request from the hazard unit |
| ic_miss | input | 1 | Instruction cache miss, freezes fetch |
| pc_q | output | 32 | Registered program counter |
| fetch_addr | output | 32 | Address presented to instruction memory |

## Verification
A stall and a redirect can arrive in the same cycle, and this collision is where the unit is most likely to go wrong. The bench raises a taken branch together with a hazard stall. It confirms that the PC stays put, then withdraws the branch while the stall remains. After the stall is released, it expects the PC to be loaded with the target formed from the held PC. It also drives a jump and a true branch together and expects the jump target, and it drives a redirect together with a cache miss and expects no movement.

// File: rtl/npc_pkg.sv
// Shared encodings for the next-PC unit.
// Assumes branch kinds are decoded upstream into a 2-bit selector.
package npc_pkg;
    typedef enum logic [1:0] {
        BK_EQ  = 2'd0,
        BK_NE  = 2'd1,
        BK_EZ  = 2'd2,
        BK_LTZ = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        PS_SEQ  = 2'd0,
        PS_NOW  = 2'd1,
        PS_PEND = 2'd2
    } pc_src_e;
endpackage

// File: rtl/npc_cond.sv
// Branch condition evaluation.
// Reduces the decode-stage comparison flags to a single taken bit.
// Assumes the comparison flags are valid whenever br_valid is high.
module npc_cond
    import npc_pkg::*;
(
    input  logic       br_valid,
    input  logic [1:0] kind,
    input  logic       cmp_eq,
    input  logic       cmp_zero,
    input  logic       cmp_neg,
    output logic       taken
);
    logic cond;

    // select the comparison named by the branch kind
    always_comb begin
        unique case (br_kind_e'(kind))
            BK_EQ:   cond = cmp_eq;
            BK_NE:   cond = !cmp_eq;
            BK_EZ:   cond = cmp_zero;
            BK_LTZ:  cond = cmp_neg;
            default: cond = 1'b0;
        endcase
    end

    assign taken = br_valid && cond;
endmodule

// File: rtl/npc_target.sv
// Sequential and redirect address computation.
// The base for both branch and jump targets is the PC of the delay-slot
// instruction, which is the instruction in fetch. Offsets are in words and
// signed. Assumes ADDR_W exceeds both offset widths by more than two.
module npc_target #(
    parameter int ADDR_W = 32,
    parameter int BOFF_W = 16,
    parameter int JOFF_W = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              use_jump,
    input  logic [BOFF_W-1:0] boff,
    input  logic [JOFF_W-1:0] joff,
    output logic [ADDR_W-1:0] seq,
    output logic [ADDR_W-1:0] tgt
);
    localparam int BEXT = ADDR_W - BOFF_W - 2;
    localparam int JEXT = ADDR_W - JOFF_W - 2;

    logic [ADDR_W-1:0] bdisp;
    logic [ADDR_W-1:0] jdisp;

    // sign-extend and scale each offset to a byte displacement
    always_comb begin
        bdisp = {{BEXT{boff[BOFF_W-1]}}, boff, 2'b00};
        jdisp = {{JEXT{joff[JOFF_W-1]}}, joff, 2'b00};
    end

    assign seq = pc + ADDR_W'(4);
    assign tgt = pc + (use_jump ? jdisp : bdisp);
endmodule

// File: rtl/npc_hold.sv
// Remembers a redirect that arrives while fetch is stalled.
// Clears on the first unstalled cycle, when the PC consumes it.
module npc_hold #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] tgt,
    output logic              pend_vld,
    output logic [ADDR_W-1:0] pend_tgt
);
    // capture a stalled redirect, drop it once the stall ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_tgt <= '0;
        end else if (stall && redirect) begin
            pend_vld <= 1'b1;
            pend_tgt <= tgt;
        end else if (!stall) begin
            pend_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/npc_unit.sv
// Next-PC unit for a decode-resolved pipeline with one delay slot.
// Picks the sequential, live-redirect or remembered-redirect address and
// loads it into the PC unless a hazard stall or cache miss freezes fetch.
// A jump takes precedence over a simultaneous branch.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              BOFF_W   = 16,
    parameter int              JOFF_W   = 26,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_branch,
    input  logic              dec_jump,
    input  logic [1:0]        br_kind,
    input  logic              cmp_eq,
    input  logic              cmp_zero,
    input  logic              cmp_neg,
    input  logic [BOFF_W-1:0] dec_imm16,
    input  logic [JOFF_W-1:0] dec_imm26,
    input  logic              hz_stall,
    input  logic              ic_miss,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic              br_taken;
    logic              redirect;
    logic              stall;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_tgt;
    pc_src_e           src;
    logic [ADDR_W-1:0] pc_d;

    npc_cond u_cond (
        .br_valid (dec_branch),
        .kind     (br_kind),
        .cmp_eq   (cmp_eq),
        .cmp_zero (cmp_zero),
        .cmp_neg  (cmp_neg),
        .taken    (br_taken)
    );

    npc_target #(
        .ADDR_W (ADDR_W),
        .BOFF_W (BOFF_W),
        .JOFF_W (JOFF_W)
    ) u_tgt (
        .pc       (pc_q),
        .use_jump (dec_jump),
        .boff     (dec_imm16),
        .joff     (dec_imm26),
        .seq      (seq_pc),
        .tgt      (tgt_pc)
    );

    assign redirect = dec_jump || br_taken;
    assign stall    = hz_stall || ic_miss;

    npc_hold #(
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .redirect (redirect),
        .tgt      (tgt_pc),
        .pend_vld (pend_vld),
        .pend_tgt (pend_tgt)
    );

    // choose the source of the next PC
    always_comb begin
        if (redirect)      src = PS_NOW;
        else if (pend_vld) src = PS_PEND;
        else               src = PS_SEQ;
        unique case (src)
            PS_NOW:  pc_d = tgt_pc;
            PS_PEND: pc_d = pend_tgt;
            default: pc_d = seq_pc;
        endcase
    end

    // PC register, write-enabled only when fetch is not frozen
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= RESET_PC;
        else if (!stall) pc_q <= pc_d;
    end

    assign fetch_addr = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
// Property checker for npc_unit, attached by bind.
// Recomputes branch decisions and displacements from the ports.
module npc_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int BOFF_W = 16,
    parameter int JOFF_W = 26,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_branch,
    input logic              dec_jump,
    input logic [1:0]        br_kind,
    input logic              cmp_eq,
    input logic              cmp_zero,
    input logic              cmp_neg,
    input logic [BOFF_W-1:0] dec_imm16,
    input logic [JOFF_W-1:0] dec_imm26,
    input logic              hz_stall,
    input logic              ic_miss,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              pend_vld
);
    logic              frz;
    logic              tk;
    logic [ADDR_W-1:0] bd;
    logic [ADDR_W-1:0] jd;

    // independent model of condition and displacements
    always_comb begin
        frz = hz_stall || ic_miss;
        case (br_kind)
            2'd0:    tk = dec_branch && cmp_eq;
            2'd1:    tk = dec_branch && !cmp_eq;
            2'd2:    tk = dec_branch && cmp_zero;
            default: tk = dec_branch && cmp_neg;
        endcase
        bd = ADDR_W'($signed(dec_imm16)) <<< 2;
        jd = ADDR_W'($signed(dec_imm26)) <<< 2;
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_PC);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && !tk && !dec_jump && !pend_vld) |=> pc_q == $past(pc_q) + ADDR_W'(4));

    // R3
    branch_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && tk && !dec_jump) |=> pc_q == $past(pc_q) + $past(bd));

    // R5
    jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && dec_jump) |=> pc_q == $past(pc_q) + $past(jd));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(pc_q));

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && (tk || dec_jump)) |=> pend_vld);

    // R8
    fetch_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr == pc_q);
endmodule

bind npc_unit npc_unit_chk #(
    .ADDR_W   (ADDR_W),
    .BOFF_W   (BOFF_W),
    .JOFF_W   (JOFF_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_branch (dec_branch),
    .dec_jump   (dec_jump),
    .br_kind    (br_kind),
    .cmp_eq     (cmp_eq),
    .cmp_zero   (cmp_zero),
    .cmp_neg    (cmp_neg),
    .dec_imm16  (dec_imm16),
    .dec_imm26  (dec_imm26),
    .hz_stall   (hz_stall),
    .ic_miss    (ic_miss),
    .pc_q       (pc_q),
    .fetch_addr (fetch_addr),
    .pend_vld   (pend_vld)
);

// File: tb/sim_npc_unit.sv
// Self-checking bench for npc_unit: vector table plus directed tests.
module sim_npc_unit;
    localparam int CLK_P = 10;
    localparam int NV    = 14;

    typedef struct packed {
        logic        br;
        logic        jp;
        logic [1:0]  kind;
        logic        eq;
        logic        zr;
        logic        ng;
        logic        hs;
        logic        ms;
        logic [15:0] i16;
        logic [25:0] i26;
        logic [31:0] delta;
        logic [7:0]  req;
    } vec_t;

    // br jp kind eq zr ng hs ms imm16 imm26 delta req
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,26'h0,       32'd4,          8'd2},
        '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0003,26'h0,       32'd12,         8'd3},
        '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0003,26'h0,       32'd4,          8'd4},
        '{1'b1,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,16'hFFFE,26'h0,       32'hFFFFFFF8,   8'd3},
        '{1'b1,1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFFE,26'h0,       32'd4,          8'd4},
        '{1'b1,1'b0,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0005,26'h0,       32'd20,         8'd3},
        '{1'b1,1'b0,2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,26'h0,       32'd4,          8'd4},
        '{1'b1,1'b0,2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0010,26'h0,       32'd64,         8'd3},
        '{1'b1,1'b0,2'd3,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0010,26'h0,       32'd4,          8'd4},
        '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,26'h0000007, 32'd28,         8'd5},
        '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,26'h3FFFFFF, 32'hFFFFFFFC,   8'd5},
        '{1'b1,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0100,26'h0000002, 32'd8,          8'd5},
        '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,26'h0,       32'd0,          8'd6},
        '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,26'h0000009, 32'd0,          8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_branch = 1'b0;
    logic        dec_jump = 1'b0;
    logic [1:0]  br_kind = 2'd0;
    logic        cmp_eq = 1'b0;
    logic        cmp_zero = 1'b0;
    logic        cmp_neg = 1'b0;
    logic [15:0] dec_imm16 = '0;
    logic [25:0] dec_imm26 = '0;
    logic        hz_stall = 1'b0;
    logic        ic_miss = 1'b0;
    logic [31:0] pc_q;
    logic [31:0] fetch_addr;

    int n_run = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = !clk;

    npc_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_branch (dec_branch),
        .dec_jump   (dec_jump),
        .br_kind    (br_kind),
        .cmp_eq     (cmp_eq),
        .cmp_zero   (cmp_zero),
        .cmp_neg    (cmp_neg),
        .dec_imm16  (dec_imm16),
        .dec_imm26  (dec_imm26),
        .hz_stall   (hz_stall),
        .ic_miss    (ic_miss),
        .pc_q       (pc_q),
        .fetch_addr (fetch_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_branch = 1'b0; dec_jump = 1'b0; br_kind = 2'd0;
        cmp_eq = 1'b0; cmp_zero = 1'b0; cmp_neg = 1'b0;
        dec_imm16 = '0; dec_imm26 = '0; hz_stall = 1'b0; ic_miss = 1'b0;
    endtask

    // apply one cycle of inputs at a falling edge and sample at the next one
    task automatic step_vec(input vec_t v);
        logic [31:0] base;
        base = pc_q;
        dec_branch = v.br; dec_jump = v.jp; br_kind = v.kind;
        cmp_eq = v.eq; cmp_zero = v.zr; cmp_neg = v.ng;
        hz_stall = v.hs; ic_miss = v.ms;
        dec_imm16 = v.i16; dec_imm26 = v.i26;
        @(posedge clk);
        @(negedge clk);
        check($sformatf("R%0d", v.req), pc_q, base + v.delta);
        check("R8", fetch_addr, pc_q);
        idle();
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] base;
        vec_t v;
        repeat (3) @(negedge clk);
        // R1: reset value
        check("R1", pc_q, 32'h0);
        rst_n = 1'b1;

        // R9: negative branch from address 0 wraps
        v = '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFFF,26'h0,32'hFFFFFFFC,8'd9};
        step_vec(v);
        check("R9", pc_q, 32'hFFFFFFFC);
        // R9: sequential step wraps back to zero
        step_vec(VEC[0]);
        check("R9", pc_q, 32'h0);

        for (int i = 0; i < NV; i++) step_vec(VEC[i]);

        // R7: taken branch during a hazard stall, dropped before release
        base = pc_q;
        dec_branch = 1'b1; br_kind = 2'd0; cmp_eq = 1'b1; dec_imm16 = 16'h0004;
        hz_stall = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7", pc_q, base);
        idle(); hz_stall = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7", pc_q, base);
        idle();
        @(posedge clk); @(negedge clk);
        check("R7", pc_q, base + 32'd16);
        @(posedge clk); @(negedge clk);
        check("R2", pc_q, base + 32'd20);

        // R7: jump during a cache miss, still present at release
        base = pc_q;
        dec_jump = 1'b1; dec_imm26 = 26'h0000003; ic_miss = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R6", pc_q, base);
        ic_miss = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7", pc_q, base + 32'd12);
        idle();

        // R4: untaken branch then delay slot and successor in order
        base = pc_q;
        dec_branch = 1'b1; br_kind = 2'd2; cmp_zero = 1'b0;
        @(posedge clk); @(negedge clk);
        idle();
        @(posedge clk); @(negedge clk);
        check("R4", pc_q, base + 32'd8);

        // R1: reset in mid-run returns the PC to zero
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", pc_q, 32'h0);
        check("R8", fetch_addr, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2", pc_q, 32'h4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule